// File: doc/BRIEF.md
# SIMT Reconvergence Mask Stack

This block steers instruction fetch for one warp: a group of lanes that share a single program counter. After each instruction the front end reports the fetch PC it has just issued. If that instruction was a branch, the front end also reports the per-lane branch outcome, the branch target, the fall-through address and the address where the two paths meet again. The block returns the PC to fetch next and the set of active lanes. Lanes outside that set still step through every instruction, but their register writes are suppressed.

When a branch splits the active lanes, the block runs the taken lanes first. It stores the work that is still pending on a small stack. Each stack slot holds three fields: a meeting address, a resume address and a lane set. When the reported PC reaches the meeting address of the newest slot, fetch is redirected to that slot's resume address, the slot's lanes become active, and the slot is removed. This handles properly nested if/else structures and loops whose lanes leave at different iterations.

Top module: `simt_reconv_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `next_pc` = START_PC, `active_mask` all ones, `overflow` low, and the stack empty. An empty stack means a later report of any PC without a branch gives PC + PC_STEP.
- R2: When `pc_valid` is high, there is no branch, and the stack is empty or its newest meeting address differs from `pc_in`, the next cycle shows `next_pc` = `pc_in` + PC_STEP with `active_mask` unchanged.
- R3: A branch is uniform when the taken set (`br_taken` AND active mask) is empty or equals the whole active mask. If the taken set is empty, fetch goes to `br_fallthru`; if it equals the whole active mask, fetch goes to `br_target`. In both cases the mask is unchanged and no slot is stored. Lane i is bit i of every mask.
- R4: A split branch sends fetch to `br_target`, and the mask becomes the taken set. Two slots are stored, both with meeting address `br_reconv`. The lower slot resumes at `br_reconv` with the pre-branch mask. The upper slot resumes at `br_fallthru` with the not-taken lanes. The upper slot is left out when `br_fallthru` equals `br_reconv`.
- R5: When `pc_in` equals the meeting address of the newest slot, the next cycle shows that slot's resume address and lane set, and the slot is removed. An empty stack never redirects.
- R6: An inner split divides only the lanes that are currently active. Reaching the inner meeting address runs the inner not-taken lanes, then restores exactly the outer path's mask.
- R7: A loop-closing branch has `br_fallthru` equal to `br_reconv`. If the slot that will be newest already resumes at that same address as its meeting address, a split stores nothing and only narrows the mask. When no lane takes the branch, fetch moves to the exit, and the next report of the exit PC restores the mask held before the loop.
- R8: If a meeting-address match and a branch arrive in the same cycle, the slot is removed first. The branch is then judged against the restored mask, and its outcome sets the next PC and mask.
- R9: A store that would exceed DEPTH slots is dropped and sets `overflow`. `overflow` stays high until reset; the slots already held are kept.
- R10: While `pc_valid` is low, `next_pc`, `active_mask` and the stack hold, whatever the branch inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_valid | input | 1 | An instruction at `pc_in` has been issued this cycle |
| pc_in | input | PC_W | PC of the issued instruction |
| br_valid | input | 1 | The issued instruction is a conditional branch (used only with `pc_valid`) |
| br_taken | input | LANES | Per-lane branch condition |
| br_target | input | PC_W | Branch destination |
| br_fallthru | input | PC_W | Address after the branch |
| br_reconv | input | PC_W | Address where the two paths meet |
| next_pc | output | PC_W | PC to fetch next |
| active_mask | output | LANES | Lanes allowed to commit results |
| overflow | output | 1 | Sticky flag: a slot was dropped |

## Verification
The embedded properties assume the front end describes well-nested control flow. Branches are reported only with `pc_valid`, every split names a meeting address that all of its paths later reach, and the active mask is never driven empty from outside. The stimulus walks a hand-written instruction trace that keeps to those rules: nested if/else, a loop whose lanes leave at different iterations, and an overlapping match-and-branch cycle. Nesting is driven past the stack depth only in the overflow scenario, and after that scenario the bench checks only behaviour that the dropped slots do not affect.

// File: rtl/simt_pkg.sv
`timescale 1ns/1ps
package simt_pkg;

    // How a reported branch resolves against the lanes that are live.
    typedef enum logic [1:0] {
        BR_NONE  = 2'd0,
        BR_FALL  = 2'd1,
        BR_TAKE  = 2'd2,
        BR_SPLIT = 2'd3
    } br_kind_e;

    function automatic br_kind_e classify_branch(
        input logic valid,
        input logic any_take,
        input logic any_fall
    );
        if (!valid)         return BR_NONE;
        else if (!any_take) return BR_FALL;
        else if (!any_fall) return BR_TAKE;
        else                return BR_SPLIT;
    endfunction

endpackage

// File: rtl/simt_branch_split.sv
`timescale 1ns/1ps
module simt_branch_split
    import simt_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic             valid,
    input  logic [LANES-1:0] live_mask,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] take_mask,
    output logic [LANES-1:0] fall_mask,
    output br_kind_e         kind
);

    always_comb begin
        take_mask = live_mask & cond;
        fall_mask = live_mask & ~cond;
        kind      = classify_branch(valid, |take_mask, |fall_mask);
    end

endmodule

// File: rtl/simt_mask_stack.sv
`timescale 1ns/1ps
module simt_mask_stack #(
    parameter int EW    = 80,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pop_i,
    input  logic                         psh_a_i,
    input  logic [EW-1:0]                ent_a_i,
    input  logic                         psh_b_i,
    input  logic [EW-1:0]                ent_b_i,
    output logic [EW-1:0]                top_o,
    output logic [EW-1:0]                under_o,
    output logic [$clog2(DEPTH+2)-1:0]   depth_o,
    output logic                         overflow_o
);

    localparam int SP_W = $clog2(DEPTH + 2);

    logic [EW-1:0]   mem [DEPTH];
    logic [SP_W-1:0] sp_q, base, slot_a, slot_b, sp_d;
    logic            wr_a, wr_b, ovf_hit, ovf_q;

    // Removal is applied first, then up to two stores above it.
    always_comb begin
        base    = (pop_i && sp_q != '0) ? sp_q - SP_W'(1) : sp_q;
        slot_a  = base;
        wr_a    = psh_a_i && (slot_a < SP_W'(DEPTH));
        slot_b  = wr_a ? base + SP_W'(1) : base;
        wr_b    = psh_b_i && (slot_b < SP_W'(DEPTH));
        ovf_hit = (psh_a_i && !wr_a) || (psh_b_i && !wr_b);
        if (wr_b)      sp_d = slot_b + SP_W'(1);
        else if (wr_a) sp_d = slot_a + SP_W'(1);
        else           sp_d = base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q  <= '0;
            ovf_q <= 1'b0;
        end else begin
            sp_q  <= sp_d;
            ovf_q <= ovf_q | ovf_hit;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_a && slot_a == SP_W'(g))      mem[g] <= ent_a_i;
            else if (wr_b && slot_b == SP_W'(g)) mem[g] <= ent_b_i;
        end
    end

    always_comb begin
        top_o   = '0;
        under_o = '0;
        for (int g = 0; g < DEPTH; g++) begin
            if (sp_q == SP_W'(g + 1)) top_o   = mem[g];
            if (sp_q == SP_W'(g + 2)) under_o = mem[g];
        end
    end

    assign depth_o    = sp_q;
    assign overflow_o = ovf_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);                                          // R9

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop_i && sp_q != '0 && !psh_a_i && !psh_b_i)
        |=> sp_q == $past(sp_q) - SP_W'(1));                       // R5

endmodule

// File: rtl/simt_reconv_stack.sv
`timescale 1ns/1ps
module simt_reconv_stack
    import simt_pkg::*;
#(
    parameter int          LANES    = 32,
    parameter int          DEPTH    = 8,
    parameter int          PC_W     = 32,
    parameter int          PC_STEP  = 4,
    parameter logic [31:0] START_PC = 32'h0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pc_valid,
    input  logic [PC_W-1:0]  pc_in,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_reconv,
    output logic [PC_W-1:0]  next_pc,
    output logic [LANES-1:0] active_mask,
    output logic             overflow
);

    localparam int EW   = 2 * PC_W + LANES;
    localparam int SP_W = $clog2(DEPTH + 2);

    typedef struct packed {
        logic [PC_W-1:0]  meet;
        logic [PC_W-1:0]  resume;
        logic [LANES-1:0] lanes;
    } slot_t;

    logic [PC_W-1:0]  pc_q, pc_d, seq_pc;
    logic [LANES-1:0] mask_q, mask_d, base_mask, take_mask, fall_mask;
    logic [EW-1:0]    top_raw, under_raw;
    slot_t            top_e, under_e, near_e, join_e, else_e;
    logic [SP_W-1:0]  depth;
    logic             hit, near_valid, loop_join_here, fall_is_meet;
    logic             push_join, push_else;
    br_kind_e         kind;

    assign top_e   = top_raw;
    assign under_e = under_raw;

    // Meeting-point match is resolved before the branch looks at the lanes.
    always_comb begin
        hit        = pc_valid && (depth != '0) && (pc_in == top_e.meet);
        base_mask  = hit ? top_e.lanes : mask_q;
        seq_pc     = hit ? top_e.resume : pc_in + PC_W'(PC_STEP);
        near_valid = hit ? (depth >= SP_W'(2)) : (depth != '0);
        near_e     = hit ? under_e : top_e;
    end

    simt_branch_split #(.LANES(LANES)) u_split (
        .valid     (pc_valid && br_valid),
        .live_mask (base_mask),
        .cond      (br_taken),
        .take_mask (take_mask),
        .fall_mask (fall_mask),
        .kind      (kind)
    );

    always_comb begin
        fall_is_meet   = (br_fallthru == br_reconv);
        loop_join_here = near_valid && (near_e.meet == br_reconv)
                         && (near_e.resume == br_reconv);
        push_join      = (kind == BR_SPLIT) && !(fall_is_meet && loop_join_here);
        push_else      = (kind == BR_SPLIT) && !fall_is_meet;
        join_e         = '{meet: br_reconv, resume: br_reconv,   lanes: base_mask};
        else_e         = '{meet: br_reconv, resume: br_fallthru, lanes: fall_mask};
    end

    always_comb begin
        unique case (kind)
            BR_FALL:  begin pc_d = br_fallthru; mask_d = base_mask; end
            BR_TAKE:  begin pc_d = br_target;   mask_d = base_mask; end
            BR_SPLIT: begin pc_d = br_target;   mask_d = take_mask; end
            default: begin
                pc_d   = pc_valid ? seq_pc    : pc_q;
                mask_d = pc_valid ? base_mask : mask_q;
            end
        endcase
    end

    simt_mask_stack #(.EW(EW), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .pop_i      (hit),
        .psh_a_i    (push_join),
        .ent_a_i    (join_e),
        .psh_b_i    (push_else),
        .ent_b_i    (else_e),
        .top_o      (top_raw),
        .under_o    (under_raw),
        .depth_o    (depth),
        .overflow_o (overflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= START_PC[PC_W-1:0];
            mask_q <= '1;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
        end
    end

    assign next_pc     = pc_q;
    assign active_mask = mask_q;

    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        mask_q != '0);                                             // R4

    AST_BRANCH_NARROWS: assert property (@(posedge clk) disable iff (rst)
        (pc_valid && br_valid && !hit)
        |=> (active_mask & ~$past(active_mask)) == '0);            // R6

    AST_UNIFORM_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
        (!hit && (kind == BR_FALL || kind == BR_TAKE))
        |=> depth == $past(depth));                                // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pc_valid |=> $stable(next_pc) && $stable(active_mask));   // R10

endmodule

// File: tb/simt_reconv_stack_tb.sv
`timescale 1ns/1ps
module simt_reconv_stack_tb;

    localparam int L = 4;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] pc;
        logic [L-1:0] mask;
        logic         ovf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pc_valid = 1'b0;
    logic [W-1:0] pc_in = '0;
    logic         br_valid = 1'b0;
    logic [L-1:0] br_taken = '0;
    logic [W-1:0] br_target = '0, br_fallthru = '0, br_reconv = '0;
    logic [W-1:0] next_pc;
    logic [L-1:0] active_mask;
    logic         overflow;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    simt_reconv_stack #(
        .LANES(L), .DEPTH(4), .PC_W(W), .PC_STEP(4), .START_PC(32'h0100)
    ) u_dut (
        .clk(clk), .rst(rst), .pc_valid(pc_valid), .pc_in(pc_in),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .next_pc(next_pc), .active_mask(active_mask), .overflow(overflow)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (next_pc !== e.pc || active_mask !== e.mask || overflow !== e.ovf) begin
            errors++;
            $display("FAIL %s: got pc=%h mask=%b ovf=%b expected pc=%h mask=%b ovf=%b",
                     e.tag, next_pc, active_mask, overflow, e.pc, e.mask, e.ovf);
        end
    endtask

    // Driver: one reported instruction per call, expected outcome queued.
    task automatic step(input logic pv, input logic [W-1:0] pc,
                        input logic bv, input logic [L-1:0] tk,
                        input logic [W-1:0] tg, input logic [W-1:0] ft,
                        input logic [W-1:0] rc,
                        input logic [W-1:0] epc, input logic [L-1:0] emask,
                        input logic eovf, input string tag);
        exp_t e;
        @(negedge clk);
        pc_valid = pv; pc_in = pc; br_valid = bv; br_taken = tk;
        br_target = tg; br_fallthru = ft; br_reconv = rc;
        e.pc = epc; e.mask = emask; e.ovf = eovf; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic seq(input logic [W-1:0] pc, input logic [W-1:0] epc,
                       input logic [L-1:0] emask, input logic eovf, input string tag);
        step(1'b1, pc, 1'b0, '0, '0, '0, '0, epc, emask, eovf, tag);
    endtask

    // Monitor: compares 5 ns after each rising edge.
    always @(posedge clk) begin
        #5;
        if (!rst && sb_q.size() > 0) compare(sb_q.pop_front());
    end

    initial begin
        #(20 * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r = '{pc: 16'h0100, mask: 4'hF, ovf: 1'b0, tag: "R1 reset state"};
        compare(r);
        @(negedge clk);
        rst = 1'b0;

        seq(16'h0100, 16'h0104, 4'hF, 0, "R2 sequential");
        step(0, 16'h0700, 1, 4'h3, 16'h0777, 16'h0778, 16'h0779, 16'h0104, 4'hF, 0, "R10 idle ignores branch");
        step(1, 16'h0104, 1, 4'hF, 16'h0200, 16'h0108, 16'h0300, 16'h0200, 4'hF, 0, "R3 uniform taken");
        step(1, 16'h0200, 1, 4'h0, 16'h0280, 16'h0204, 16'h0300, 16'h0204, 4'hF, 0, "R3 uniform not taken");
        step(1, 16'h0204, 1, 4'h3, 16'h0210, 16'h0208, 16'h0240, 16'h0210, 4'h3, 0, "R4 outer split");
        step(1, 16'h0210, 1, 4'h5, 16'h0220, 16'h0214, 16'h0230, 16'h0220, 4'h1, 0, "R6 inner split gated");
        seq(16'h0220, 16'h0224, 4'h1, 0, "R2 inner then");
        seq(16'h0230, 16'h0214, 4'h2, 0, "R5 inner else resume");
        seq(16'h0230, 16'h0230, 4'h3, 0, "R6 inner join restores");
        seq(16'h0230, 16'h0234, 4'h3, 0, "R5 no match proceeds");
        seq(16'h0240, 16'h0208, 4'hC, 0, "R5 outer else resume");
        step(1, 16'h0208, 1, 4'h3, 16'h0400, 16'h020C, 16'h0500, 16'h020C, 4'hC, 0, "R3 inactive lanes ignored");
        seq(16'h0240, 16'h0240, 4'hF, 0, "R6 outer join restores");
        seq(16'h0240, 16'h0244, 4'hF, 0, "R5 empty stack no redirect");
        // loop with lanes leaving at different iterations
        step(1, 16'h0260, 1, 4'hE, 16'h0250, 16'h0264, 16'h0264, 16'h0250, 4'hE, 0, "R7 loop first exit");
        step(1, 16'h0260, 1, 4'hC, 16'h0250, 16'h0264, 16'h0264, 16'h0250, 4'hC, 0, "R7 loop narrows");
        step(1, 16'h0260, 1, 4'h0, 16'h0250, 16'h0264, 16'h0264, 16'h0264, 4'hC, 0, "R7 loop all leave");
        seq(16'h0264, 16'h0264, 4'hF, 0, "R7 loop exit restores");
        seq(16'h0264, 16'h0268, 4'hF, 0, "R7 single slot for loop");
        // match and branch in one cycle
        step(1, 16'h0300, 1, 4'h3, 16'h0310, 16'h0304, 16'h0304, 16'h0310, 4'h3, 0, "R4 split without else slot");
        step(1, 16'h0304, 1, 4'h4, 16'h0380, 16'h0308, 16'h0390, 16'h0380, 4'h4, 0, "R8 pop then branch");
        seq(16'h0390, 16'h0308, 4'hB, 0, "R8 else of restored mask");
        seq(16'h0390, 16'h0390, 4'hF, 0, "R8 join after overlap");
        // overflow
        step(1, 16'h0400, 1, 4'h7, 16'h0410, 16'h0404, 16'h0480, 16'h0410, 4'h7, 0, "R9 depth two");
        step(1, 16'h0410, 1, 4'h3, 16'h0420, 16'h0414, 16'h0470, 16'h0420, 4'h3, 0, "R9 depth full");
        step(1, 16'h0420, 1, 4'h1, 16'h0430, 16'h0424, 16'h0460, 16'h0430, 4'h1, 1, "R9 overflow set");
        seq(16'h0430, 16'h0434, 4'h1, 1, "R9 overflow sticky");
        seq(16'h0470, 16'h0414, 4'h4, 1, "R9 held slots intact");

        @(negedge clk);
        pc_valid = 1'b0; br_valid = 1'b0;
        while (sb_q.size() > 0) @(negedge clk);

        rst = 1'b1;
        repeat (2) @(negedge clk);
        r = '{pc: 16'h0100, mask: 4'hF, ovf: 1'b0, tag: "R1 reset clears flag"};
        compare(r);
        rst = 1'b0;
        seq(16'h0470, 16'h0474, 4'hF, 0, "R1 stack emptied");
        @(negedge clk);
        pc_valid = 1'b0;
        while (sb_q.size() > 0) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule